// File: doc/BRIEF.md
# Link Output Formatter

The formatter takes one event of readout data as a stream of channel pairs. Each beat carries one 18-bit word from channel A and one from channel B. Bits [15:0] of a word are data, bit 16 is parity and bit 17 is an error flag. The block stores a whole event of `BEATS` pairs (36 by default, so 72 words) in an internal buffer. It then sends the event to a parallel output link as 32-bit words, in this order:

1. A start word.
2. One joined data word per beat.
3. Packed end words that hold every parity and error flag.
4. A trailer that holds the word count and an error summary.

The output is a valid/ready stream. A word moves when `out_valid` and `out_ready` are both high at a rising edge, and that handshake is the link write strobe. The link applies back-pressure by holding `out_ready` low. While it does, `out_valid` and `out_word` stay unchanged and no word is lost or reordered. After each accepted word the block leaves `GAP` idle cycles, which sets the link word rate from the core clock.

The input is also a valid/ready stream. `in_ready` is low, and `busy` is high, from the last beat of an event until that event's trailer has been accepted. While `in_ready` is low, input is ignored.

Top module: `lof_formatter`

## Requirements
- R1: After reset, and whenever no stored event is waiting to be sent, `in_ready` is high and each input handshake stores one pair. The handshake that stores pair number `BEATS` raises `busy` and drops `in_ready` from the next cycle. While `in_ready` is low, input is ignored and the stored event is not changed.
- R2: The first word of every event is the start word 0x1FFFFFFF.
- R3: Words 1 to `BEATS` are the joined data words, in beat order. Each is {channel A bits[15:0], channel B bits[15:0]}, with A in the upper half.
- R4: The next 5 words carry the flags. Flag pair k is numbered 2*beat+channel, where A=0 and B=1. In end word j, bits [2i+1:2i] hold {error bit 17, parity bit 16} of pair 16j+i. Bits for pairs beyond the last (the upper half of the fifth word) are zero.
- R5: The last word of an event is the trailer. Bit 31 is the OR of all 72 error bits of the event, bits [15:0] hold 43 (the total words per event), and all other bits are zero. `out_last` is high with this word and with no other word.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` keeps its value on the next cycle.
- R7: After each accepted output word, `out_valid` is low for exactly `GAP` cycles (2 by default), and then rises again if a word is pending.
- R8: During and after reset, before any input, `out_valid` is low, `busy` is low and `in_ready` is high.
- R9: In the cycle after the trailer is accepted, `busy` is low and `in_ready` is high, and a new event can be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair is valid |
| in_ready | output | 1 | Block can take an input pair |
| in_chan_a | input | 18 | Channel A word: {error, parity, data[15:0]} |
| in_chan_b | input | 18 | Channel B word: {error, parity, data[15:0]} |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Link can take a word; low applies back-pressure |
| out_word | output | 32 | Output link word |
| out_last | output | 1 | Marks the trailer word |
| busy | output | 1 | A stored event is still being sent |

## Verification
The bench drives inputs and samples outputs on the falling edge.

- **Input flags.** `busy` and `in_ready` change one edge after the last input handshake, so they are checked at the first falling edge after that beat.
- **Output words.** An output word is checked at the falling edge where both `out_valid` and the bench's `out_ready` choice are high, because the handshake happens at the rising edge that follows.
- **Back-pressure and pacing.** A stalled word must reappear unchanged at the next falling edge. `out_valid` must stay low on exactly the `GAP` falling edges that follow an accepted word.
- **End of event.** `busy` must be clear at the first falling edge after the trailer handshake.

// File: rtl/lof_pkg.sv
package lof_pkg;
  localparam logic [31:0] LOF_START_WORD = 32'h1FFF_FFFF;

  typedef enum logic [1:0] {
    KIND_START = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_FLAG  = 2'd2,
    KIND_TAIL  = 2'd3
  } word_kind_t;
endpackage

// File: rtl/lof_collect.sv
module lof_collect #(
  parameter int BEATS      = 36,
  parameter int FLAG_WORDS = 5,
  localparam int IDXW      = $clog2(BEATS),
  localparam int FWW       = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_fire,
  input  logic [17:0]     chan_a,
  input  logic [17:0]     chan_b,
  input  logic            ev_done,
  input  logic [IDXW-1:0] rd_beat,
  input  logic [FWW-1:0]  rd_flag,
  output logic [31:0]     beat_word,
  output logic [31:0]     flag_word,
  output logic            any_err,
  output logic            ev_ready
);
  localparam int PAIR_BITS = 4 * BEATS;
  localparam int FLAG_BITS = 32 * FLAG_WORDS;
  localparam int FBW       = $clog2(FLAG_BITS);

  logic [31:0]          mem_q [BEATS];
  logic [IDXW-1:0]      wr_q;
  logic [PAIR_BITS-1:0] flags_q;
  logic [FLAG_BITS-1:0] flags_pad;
  logic [FBW-1:0]       fbase;
  logic [31:0]          fw [FLAG_WORDS];

  assign fbase     = FBW'(wr_q) << 2;
  assign flags_pad = FLAG_BITS'(flags_q);

  always_ff @(posedge clk) begin
    if (in_fire) mem_q[wr_q] <= {chan_a[15:0], chan_b[15:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      flags_q  <= '0;
      any_err  <= 1'b0;
      ev_ready <= 1'b0;
    end else begin
      if (ev_done) ev_ready <= 1'b0;
      if (in_fire) begin
        flags_q[fbase +: 2]      <= {chan_a[17], chan_a[16]};
        flags_q[fbase + 2 +: 2]  <= {chan_b[17], chan_b[16]};
        any_err <= ((wr_q == '0) ? 1'b0 : any_err) | chan_a[17] | chan_b[17];
        if (wr_q == IDXW'(BEATS - 1)) begin
          wr_q     <= '0;
          ev_ready <= 1'b1;
        end else begin
          wr_q <= wr_q + 1'b1;
        end
      end
    end
  end

  for (genvar j = 0; j < FLAG_WORDS; j++) begin : g_fw
    assign fw[j] = flags_pad[32*j +: 32];
  end

  assign beat_word = mem_q[rd_beat];
  assign flag_word = fw[rd_flag];
endmodule

// File: rtl/lof_seq.sv
module lof_seq
  import lof_pkg::*;
#(
  parameter int          BEATS      = 36,
  parameter int          FLAG_WORDS = 5,
  parameter int          GAP        = 2,
  parameter logic [31:0] START_WORD = LOF_START_WORD,
  localparam int IDXW     = $clog2(BEATS),
  localparam int FWW      = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1,
  localparam int EV_WORDS = BEATS + FLAG_WORDS + 2,
  localparam int CW       = $clog2(EV_WORDS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_ready,
  input  logic [31:0]     beat_word,
  input  logic [31:0]     flag_word,
  input  logic            any_err,
  output logic [IDXW-1:0] rd_beat,
  output logic [FWW-1:0]  rd_flag,
  output logic            ev_done,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_word,
  output logic            out_last
);
  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_m1;
  word_kind_t    kind;
  logic          gap_clear;
  logic          fire;

  always_comb begin
    if (idx_q == '0)                            kind = KIND_START;
    else if (idx_q <= CW'(BEATS))               kind = KIND_DATA;
    else if (idx_q <= CW'(BEATS + FLAG_WORDS))  kind = KIND_FLAG;
    else                                        kind = KIND_TAIL;
  end

  assign idx_m1  = idx_q - 1'b1;
  assign rd_beat = IDXW'(idx_m1);
  assign rd_flag = FWW'(idx_m1 - CW'(BEATS));

  always_comb begin
    unique case (kind)
      KIND_START: out_word = START_WORD;
      KIND_DATA:  out_word = beat_word;
      KIND_FLAG:  out_word = flag_word;
      default:    out_word = {any_err, 15'd0, 16'(EV_WORDS)};
    endcase
  end

  assign out_valid = ev_ready && gap_clear;
  assign out_last  = out_valid && (kind == KIND_TAIL);
  assign fire      = out_valid && out_ready;
  assign ev_done   = fire && (kind == KIND_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (ev_done) idx_q <= '0;
    else if (fire)    idx_q <= idx_q + 1'b1;
  end

  if (GAP > 0) begin : g_pace
    localparam int GW = $clog2(GAP + 1);
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap_q <= '0;
      else if (fire)           gap_q <= GW'(GAP);
      else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
    end
    assign gap_clear = (gap_q == '0);
  end else begin : g_nopace
    assign gap_clear = 1'b1;
  end
endmodule

// File: rtl/lof_formatter.sv
module lof_formatter
  import lof_pkg::*;
#(
  parameter int          BEATS      = 36,
  parameter int          FLAG_WORDS = (2 * BEATS + 15) / 16,
  parameter int          GAP        = 2,
  parameter logic [31:0] START_WORD = LOF_START_WORD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [17:0] in_chan_a,
  input  logic [17:0] in_chan_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic        out_last,
  output logic        busy
);
  localparam int IDXW = $clog2(BEATS);
  localparam int FWW  = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1;

  logic            ev_ready, ev_done, any_err, in_fire;
  logic [IDXW-1:0] rd_beat;
  logic [FWW-1:0]  rd_flag;
  logic [31:0]     beat_word, flag_word;

  assign in_ready = !ev_ready;
  assign busy     = ev_ready;
  assign in_fire  = in_valid && in_ready;

  lof_collect #(.BEATS(BEATS), .FLAG_WORDS(FLAG_WORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
    .chan_a(in_chan_a), .chan_b(in_chan_b), .ev_done(ev_done),
    .rd_beat(rd_beat), .rd_flag(rd_flag),
    .beat_word(beat_word), .flag_word(flag_word),
    .any_err(any_err), .ev_ready(ev_ready)
  );

  lof_seq #(.BEATS(BEATS), .FLAG_WORDS(FLAG_WORDS), .GAP(GAP),
            .START_WORD(START_WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready),
    .beat_word(beat_word), .flag_word(flag_word), .any_err(any_err),
    .rd_beat(rd_beat), .rd_flag(rd_flag), .ev_done(ev_done),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_last(out_last)
  );
endmodule

// File: rtl/lof_checker.sv
module lof_checker #(
  parameter int          BEATS      = 36,
  parameter int          FLAG_WORDS = 5,
  parameter int          GAP        = 2,
  parameter logic [31:0] START_WORD = 32'h1FFF_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_last,
  input logic        busy
);
  localparam int EV_WORDS = BEATS + FLAG_WORDS + 2;

  logic     first_q;
  int unsigned wcnt_q;
  logic     ofire;

  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      wcnt_q  <= 0;
    end else if (ofire) begin
      first_q <= out_last;
      wcnt_q  <= out_last ? 0 : wcnt_q + 1;
    end
  end

  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_word));
  a_r2_start_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && first_q) |-> (out_word == START_WORD));
  a_r5_last_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ofire && out_last) |-> (wcnt_q == EV_WORDS - 1));
  a_r5_last_only_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (ofire && (wcnt_q == EV_WORDS - 1)) |-> out_last);
  a_r1_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ofire && out_last));

  if (GAP > 0) begin : g_gap
    a_r7_gap_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      ofire |=> !out_valid);
  end
endmodule

bind lof_formatter lof_checker #(
  .BEATS(BEATS), .FLAG_WORDS(FLAG_WORDS), .GAP(GAP), .START_WORD(START_WORD)
) u_lof_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_last(out_last), .busy(busy)
);

// File: tb/lof_formatter_bench.sv
module lof_formatter_bench;
  localparam int BEATS    = 36;
  localparam int FW       = 5;
  localparam int GAP      = 2;
  localparam int EV_WORDS = BEATS + FW + 2;
  localparam logic [31:0] START = 32'h1FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_chan_a = '0;
  logic [17:0] in_chan_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_last;
  logic        busy;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned cyc      = 0;
  bit          finished = 1'b0;

  logic [17:0] ev_a [BEATS];
  logic [17:0] ev_b [BEATS];

  always #2 clk = ~clk;

  lof_formatter u_lof_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan_a(in_chan_a), .in_chan_b(in_chan_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  function automatic logic [31:0] exp_word(int w);
    logic [31:0] r;
    logic [17:0] src;
    int j, k;
    if (w == 0) return START;
    if (w <= BEATS) return {ev_a[w-1][15:0], ev_b[w-1][15:0]};
    if (w <= BEATS + FW) begin
      r = '0;
      j = w - 1 - BEATS;
      for (int i = 0; i < 16; i++) begin
        k = 16 * j + i;
        if (k < 2 * BEATS) begin
          src = (k % 2 == 0) ? ev_a[k/2] : ev_b[k/2];
          r[2*i +: 2] = {src[17], src[16]};
        end
      end
      return r;
    end
    r = {16'd0, 16'(EV_WORDS)};
    for (int i = 0; i < BEATS; i++) r[31] = r[31] | ev_a[i][17] | ev_b[i][17];
    return r;
  endfunction

  function automatic string tag_of(int w);
    if (w == 0) return "R2";
    if (w <= BEATS) return "R3";
    if (w <= BEATS + FW) return "R4";
    return "R5";
  endfunction

  task automatic fill_event(input int e);
    for (int i = 0; i < BEATS; i++) begin
      ev_a[i] = 18'($urandom);
      ev_b[i] = 18'($urandom);
      case (e)
        0: begin ev_a[i][17:16] = 2'b00; ev_b[i][17:16] = 2'b00; end
        1: begin ev_a[i][17:16] = 2'b11; ev_b[i][17:16] = 2'b11; end
        2: begin
          ev_a[i][17] = 1'b0;
          ev_b[i][17] = (i == BEATS - 1);
        end
        default: begin
          ev_a[i][17] = ($urandom % 8) == 0;
          ev_b[i][17] = ($urandom % 8) == 0;
        end
      endcase
    end
  endtask

  task automatic send_event();
    for (int i = 0; i < BEATS; i++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      chk(in_ready == 1'b1, "R1 ready while filling", 32'(in_ready), 32'd1);
      in_valid  = 1'b1;
      in_chan_a = ev_a[i];
      in_chan_b = ev_b[i];
    end
    @(negedge clk);
    // R1: stored event now waiting; keep junk on the input, which must be ignored
    chk(busy == 1'b1 && in_ready == 1'b0, "R1 busy after last beat",
        {30'd0, busy, in_ready}, 32'h2);
    in_valid  = 1'b1;
    in_chan_a = 18'h3FFFF;
    in_chan_b = 18'h2AAAA;
  endtask

  task automatic recv_event(input int e);
    int w = 0;
    int gap_left = 0;
    int stall = 0;
    bit pend = 1'b0;
    logic [31:0] pw = '0;
    bit rdy;
    while (w < EV_WORDS) begin
      if (gap_left > 0) begin
        chk(out_valid == 1'b0, "R7 gap after word", 32'(out_valid), 32'd0);
        gap_left--;
      end
      if (pend) begin
        chk(out_valid == 1'b1 && out_word == pw, "R6 held under stall", out_word, pw);
        pend = 1'b0;
      end
      rdy = ($urandom % 4) != 0;
      if (e == 2 && w == 20 && stall < 10) begin
        rdy = 1'b0;
        stall++;
      end
      out_ready = rdy;
      if (out_valid) begin
        if (rdy) begin
          chk(out_word == exp_word(w), tag_of(w), out_word, exp_word(w));
          chk(out_last == (w == EV_WORDS - 1), "R5 last flag",
              32'(out_last), 32'(w == EV_WORDS - 1));
          w++;
          gap_left = GAP;
        end else begin
          pend = 1'b1;
          pw   = out_word;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(busy == 1'b0 && in_ready == 1'b1, "R9 free after trailer",
        {30'd0, busy, in_ready}, 32'h1);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_fails++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0 && in_ready == 1'b1, "R8 in reset",
        {29'd0, out_valid, busy, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && busy == 1'b0 && in_ready == 1'b1, "R8 after reset",
        {29'd0, out_valid, busy, in_ready}, 32'h1);
    for (int e = 0; e < 7; e++) begin
      fill_event(e);
      send_event();
      recv_event(e);
    end
    finished = 1'b1;
    summary();
  end
endmodule